// File: doc/BRIEF.md
# Branch Target Prediction Table

This block sits beside the fetch stage and answers one question per cycle: for the instruction address being fetched, is there a branch the block has seen before, will it be taken, and where will it go? The block keeps a direct-mapped table. Each slot holds a valid flag, an address tag, the target that the branch jumped to last time, and a 2-bit saturating confidence counter. The fetch stage sends a lookup address. One cycle later the block returns a hit flag, a taken prediction and the next fetch address. That address is either the stored target or the sequential fall-through address.

When a branch resolves further down the pipeline, the resolve port reports its address, its outcome and its real target. A taken branch that misses in the table claims its slot and overwrites whatever was there. A branch that hits moves its counter one step toward its outcome. A taken hit also refreshes the stored target. If a resolve and a lookup touch the same slot in the same cycle, the lookup result reflects the resolve.

Top module: `branch_target_cache`

## Requirements
- R1: After synchronous reset every slot is invalid, so any lookup returns hit=0 and taken=0.
- R2: With the defaults (32-bit addresses, 128 slots, 4-byte instructions), address bits [8:2] select the slot and bits [31:9] form the tag. Two addresses with the same slot bits and different tags compete for one slot, and the newer allocation evicts the older one.
- R3: A lookup presented with `lk_valid` high yields `rsp_valid` high exactly one cycle later. A cycle without a lookup yields `rsp_valid` low one cycle later. Back-to-back lookups give back-to-back responses in order.
- R4: `rsp_hit` is 1 only when the slot is valid and its tag equals the lookup tag. `rsp_taken` is 1 only on a hit whose counter is 2 or 3.
- R5: Whenever `rsp_taken` is 0, `rsp_target` equals the lookup address plus 4.
- R6: A taken resolve that misses allocates the slot. The slot gets valid=1, the new tag and target, and counter 2, so the next lookup of that address predicts taken to that target.
- R7: A not-taken resolve that misses leaves the table unchanged, so the address still misses.
- R8: A resolve that hits increments the counter when taken, saturating at 3.
- R9: A resolve that hits decrements the counter when not taken, saturating at 0. The slot stays valid, so lookups hit but predict fall-through.
- R10: A taken resolve that hits replaces the stored target with the reported one.
- R11: A resolve and a lookup of the same slot in the same cycle return the post-resolve slot contents (valid, tag, target, counter).
- R12: Slots with different index bits are independent. A resolve to one slot does not change the prediction of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Slot valid and tag matched |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Branch resolve this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |

## Verification
Every lookup result is due exactly one clock edge after the request cycle. A resolve changes the table at the edge that ends its cycle, so a lookup in the following cycle already sees the change. A lookup in the same cycle as the resolve sees it through forwarding. The driver pushes one expected response per lookup into a queue and changes inputs just after each rising edge. The monitor samples the outputs on the falling edge and pops one expectation for every cycle in which `rsp_valid` is high. A late, early or missing response therefore appears as a mismatch or as a queue left non-empty. Counter sequences are chosen so that a counter that wraps instead of saturating ends in the opposite prediction.

// File: rtl/btc_pkg.sv
// Shared types and helpers for the branch target cache.
// Assumes a 2-bit confidence counter; values 2 and 3 mean "predict taken".
package btc_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN    = 2'd0;
    localparam ctr_t CTR_MAX    = 2'd3;
    localparam ctr_t CTR_WEAK_T = 2'd2;

    // Move a counter one step toward the outcome, saturating at both ends.
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken)
            return (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
        else
            return (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    endfunction

    // Prediction is taken for the upper half of the counter range.
    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/btc_addr_split.sv
// Splits an instruction address into slot index and tag.
// Assumes the low ALIGN bits are always zero and are therefore dropped.
module btc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 2,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - ALIGN
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    // Pure wiring: index above the alignment bits, tag above the index.
    always_comb begin
        idx = pc[ALIGN +: IDX_W];
        tag = pc[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/btc_store.sv
// Slot storage: per-slot valid (reset), tag, target and counter (no reset).
// One write port and two combinational read ports (lookup and resolve).
module btc_store
    import btc_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int TAG_W   = 23,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  ctr_t              wr_ctr,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_vld,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [ADDR_W-1:0] ra_tgt,
    output ctr_t              ra_ctr,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_vld,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [ADDR_W-1:0] rb_tgt,
    output ctr_t              rb_ctr
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Valid flag: cleared by reset, set by any write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)   vld_q[e] <= 1'b0;
            else if (sel) vld_q[e] <= 1'b1;
        end

        // Payload: written with the slot, no reset needed behind valid.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
                ctr_q[e] <= wr_ctr;
            end
        end
    end

    // Read ports: asynchronous selects of the addressed slot.
    always_comb begin
        ra_vld = vld_q[ra_idx];
        ra_tag = tag_q[ra_idx];
        ra_tgt = tgt_q[ra_idx];
        ra_ctr = ctr_q[ra_idx];
        rb_vld = vld_q[rb_idx];
        rb_tag = tag_q[rb_idx];
        rb_tgt = tgt_q[rb_idx];
        rb_ctr = ctr_q[rb_idx];
    end

    // R6: every write leaves its slot valid on the next cycle.
    a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/btc_update.sv
// Resolve logic: decides whether a resolved branch writes its slot and
// computes the new slot contents (allocate on taken miss, train on hit).
// Assumes the current slot contents are supplied combinationally.
module btc_update
    import btc_pkg::*;
#(
    parameter int TAG_W  = 23,
    parameter int ADDR_W = 32
) (
    input  logic              rs_valid,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target,
    input  logic [TAG_W-1:0]  rs_tag,
    input  logic              cur_vld,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [ADDR_W-1:0] cur_tgt,
    input  ctr_t              cur_ctr,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_tgt,
    output ctr_t              wr_ctr
);
    logic match;

    // Next-slot selection: train on hit, allocate on taken miss, else hold.
    always_comb begin
        match  = cur_vld && (cur_tag == rs_tag);
        wr_tag = rs_tag;
        wr_tgt = cur_tgt;
        wr_ctr = cur_ctr;
        wr_en  = 1'b0;
        if (rs_valid && match) begin
            wr_en  = 1'b1;
            wr_ctr = ctr_step(cur_ctr, rs_taken);
            if (rs_taken) wr_tgt = rs_target;
        end else if (rs_valid && rs_taken) begin
            wr_en  = 1'b1;
            wr_tgt = rs_target;
            wr_ctr = CTR_WEAK_T;
        end
    end
endmodule

// File: rtl/branch_target_cache.sv
// Direct-mapped branch target cache with 2-bit confidence counters.
// Lookups return one cycle later; a same-slot resolve is forwarded.
// Assumes aligned instructions of 2**ALIGN bytes.
module branch_target_cache
    import btc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128,
    parameter int ALIGN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_taken,
    output logic [ADDR_W-1:0] rsp_target,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - ALIGN;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    logic [IDX_W-1:0]  lk_idx, rs_idx;
    logic [TAG_W-1:0]  lk_tag, rs_tag;
    logic              ra_vld, rb_vld, wr_en;
    logic [TAG_W-1:0]  ra_tag, rb_tag, wr_tag;
    logic [ADDR_W-1:0] ra_tgt, rb_tgt, wr_tgt;
    ctr_t              ra_ctr, rb_ctr, wr_ctr;

    btc_addr_split #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .IDX_W(IDX_W)) u_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
    btc_addr_split #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .IDX_W(IDX_W)) u_rs_split (
        .pc(rs_pc), .idx(rs_idx), .tag(rs_tag));

    btc_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(rs_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr),
        .ra_idx(lk_idx), .ra_vld(ra_vld), .ra_tag(ra_tag), .ra_tgt(ra_tgt), .ra_ctr(ra_ctr),
        .rb_idx(rs_idx), .rb_vld(rb_vld), .rb_tag(rb_tag), .rb_tgt(rb_tgt), .rb_ctr(rb_ctr));

    btc_update #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_update (
        .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_target(rs_target), .rs_tag(rs_tag),
        .cur_vld(rb_vld), .cur_tag(rb_tag), .cur_tgt(rb_tgt), .cur_ctr(rb_ctr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr));

    logic              fwd, sel_vld, hit_d, taken_d;
    logic [TAG_W-1:0]  sel_tag;
    logic [ADDR_W-1:0] sel_tgt, tgt_d;
    ctr_t              sel_ctr;

    // Lookup: forward a same-slot write, then match and predict.
    always_comb begin
        fwd     = wr_en && (rs_idx == lk_idx);
        sel_vld = fwd ? 1'b1   : ra_vld;
        sel_tag = fwd ? wr_tag : ra_tag;
        sel_tgt = fwd ? wr_tgt : ra_tgt;
        sel_ctr = fwd ? wr_ctr : ra_ctr;
        hit_d   = sel_vld && (sel_tag == lk_tag);
        taken_d = hit_d && ctr_says_taken(sel_ctr);
        tgt_d   = taken_d ? sel_tgt : lk_pc + STEP;
    end

    // Response register: one-cycle lookup latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_taken  <= 1'b0;
            rsp_target <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && hit_d;
            rsp_taken  <= lk_valid && taken_d;
            rsp_target <= tgt_d;
        end
    end

    // R3: a request produces a response exactly one cycle later.
    a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R3: no response without a request in the previous cycle.
    a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R4: a taken prediction always comes from a hit.
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_taken) |-> rsp_hit);
    // R5: a fall-through prediction points at the next sequential address.
    a_r5_fallthrough_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid ##1 (rsp_valid && !rsp_taken)) |-> rsp_target == $past(lk_pc) + STEP);
    // R7: a not-taken resolve that misses the stored slot writes nothing.
    a_r7_nt_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken && !(rb_vld && rb_tag == rs_tag)) |-> !wr_en);
endmodule

// File: tb/branch_target_cache_bench.sv
// Scoreboard bench: the driver queues one expectation per lookup, the
// monitor pops and compares on the falling edge when rsp_valid is high.
module branch_target_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        rsp_valid, rsp_hit, rsp_taken;
    logic [31:0] rsp_target;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    branch_target_cache u_branch_target_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target));

    typedef struct {
        logic        hit;
        logic        taken;
        logic [31:0] tgt;
        string       req;
    } exp_t;
    exp_t q[$];

    localparam logic [31:0] PA = 32'h0000_1004;  // slot 1
    localparam logic [31:0] PB = 32'h0000_1204;  // slot 1, other tag
    localparam logic [31:0] PC = 32'h0000_1008;  // slot 2

    // One cycle of stimulus; inputs change just after a rising edge.
    task automatic step(input bit dl, input logic [31:0] lpc,
                        input bit du, input logic [31:0] upc, input bit ut, input logic [31:0] utgt,
                        input bit eh, input bit et, input logic [31:0] etgt, input string req);
        exp_t e;
        if (dl) begin
            e.hit = eh; e.taken = et; e.tgt = etgt; e.req = req;
            q.push_back(e);
        end
        lk_valid = dl; lk_pc = lpc;
        rs_valid = du; rs_pc = upc; rs_taken = ut; rs_target = utgt;
        @(posedge clk); #1;
        lk_valid = 1'b0; rs_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input bit eh, input bit et,
                        input logic [31:0] etgt, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, eh, et, etgt, req);
    endtask

    task automatic upd(input logic [31:0] pc, input bit t, input logic [31:0] tgt);
        step(1'b0, '0, 1'b1, pc, t, tgt, 1'b0, 1'b0, '0, "");
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected response: actual=valid expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_hit !== e.hit || rsp_taken !== e.taken || rsp_target !== e.tgt) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b taken=%0b tgt=%h expected hit=%0b taken=%0b tgt=%h",
                             e.req, rsp_hit, rsp_taken, rsp_target, e.hit, e.taken, e.tgt);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset response: actual=%0b expected=0", rsp_valid);
        end
        @(posedge clk); #1;

        look(PA, 0, 0, PA + 4, "R1 empty after reset");
        upd(PA, 0, 32'h0000_2000);
        look(PA, 0, 0, PA + 4, "R7 not-taken miss no alloc");
        upd(PA, 1, 32'h0000_2000);
        look(PA, 1, 1, 32'h0000_2000, "R6 alloc weak taken");
        upd(PA, 0, '0);                         // ctr 1
        look(PA, 1, 0, PA + 4, "R9 decrement to fall-through");
        upd(PA, 0, '0);                         // 0
        upd(PA, 0, '0);                         // 0 (saturates)
        upd(PA, 1, 32'h0000_2000);              // 1
        upd(PA, 1, 32'h0000_2000);              // 2
        look(PA, 1, 1, 32'h0000_2000, "R9 saturate at 0 then R8 increment");
        upd(PA, 1, 32'h0000_2000);              // 3
        upd(PA, 1, 32'h0000_2000);              // 3 (saturates)
        upd(PA, 0, '0);                         // 2
        upd(PA, 0, '0);                         // 1
        look(PA, 1, 0, PA + 4, "R8 saturate at 3");
        upd(PA, 1, 32'h0000_3000);              // 2, new target
        look(PA, 1, 1, 32'h0000_3000, "R10 target refresh");
        look(PB, 0, 0, PB + 4, "R2 alias tag misses");
        upd(PB, 1, 32'h0000_4000);
        look(PB, 1, 1, 32'h0000_4000, "R2 alias allocates");
        look(PA, 0, 0, PA + 4, "R2 older tag evicted");
        look(PC, 0, 0, PC + 4, "R12 other slot untouched");
        step(1'b1, PC, 1'b1, PC, 1'b1, 32'h0000_5000, 1, 1, 32'h0000_5000, "R11 same-cycle forward");
        look(PB, 1, 1, 32'h0000_4000, "R3 back-to-back first");
        look(PC, 1, 1, 32'h0000_5000, "R3 back-to-back second");
        look(PA, 0, 0, PA + 4, "R3 back-to-back third");
        upd(PC, 0, '0);                         // slot 2 ctr 1
        look(PB, 1, 1, 32'h0000_4000, "R12 resolve elsewhere keeps slot 1");

        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R3 missing responses: actual=%0d pending expected=0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule